// File: doc/BRIEF.md
# Bus Arbiter with Guaranteed Ownership Slice

This block arbitrates a shared bus among four initiators. Each initiator raises a request line, and the arbiter returns a registered grant to one of them. A winner is picked by rotating priority. The search starts at the agent just after the most recent owner, so every requester gets a turn.

An 8-bit read/write configuration register sets a minimum ownership slice in bus clocks. The two low bits are tied to zero, so the slice moves in steps of four clocks. The slice is counted from the first cycle a grant is asserted. While the owner keeps requesting and the slice is still running, the grant does not move, even if other agents are waiting, so the owner can run back-to-back transfers. After the slice runs out, the grant passes to a waiting agent at once. If no other agent is waiting, the owner keeps the grant. A register value of zero turns the slice off.

A change of owner always goes through one cycle with no grant asserted. The slice length is captured when a grant is issued. A register write made during a slice therefore applies from the next grant onward.

Top module: `bus_slice_arbiter`

## Requirements
- R1: The configuration register resets to 0x20. A write stores data bits 7:2. Read data bits 1:0 are always 0, so writing 0xFF reads back 0xFC.
- R2: `gnt_o` is registered and is always one-hot or all zero. A grant issued from the idle state goes only to an agent whose request was high in the previous cycle. Bit k of `gnt_o` and bit k of `req_i` belong to agent k.
- R3: When ownership passes from one agent to another, exactly one cycle with `gnt_o` all zero separates the two grants.
- R4: Let N be the register value. If the owner keeps requesting and another agent is requesting, the grant stays high for exactly max(N,1) cycles, counted from its first cycle. It is never shorter while the owner requests.
- R5: A register value of 0 disables the slice. Under contention, each grant then lasts one cycle.
- R6: After the slice has expired, the owner keeps the grant for as long as no other agent requests. When another agent requests, the grant drops in the next cycle.
- R7: The next owner is the first requesting agent in the order owner+1, owner+2, and so on, wrapping modulo 4.
- R8: If the owner drops its request while another agent is requesting, the grant drops in the next cycle, even if the slice has not expired.
- R9: A register write made while a grant is held does not change that grant's slice. The new value applies from the next grant.
- R10: After reset no grant is asserted. Agent 0 has the highest priority for the first grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration register read data |
| req_i | input | 4 | Request line per agent |
| gnt_o | output | 4 | Registered grant line per agent |

## Verification
Two situations are the hardest to create from the ports. The first is a register write that lands in the middle of a running slice. The bench counts grant cycles while it writes a new value on the second cycle of a contended grant. It then checks that the current grant still runs for the old length and that the next grant uses the new one. The second is an early hand-off. The bench drops the owner's request a few cycles into a long slice while a competitor waits, and checks that the grant drops in the next cycle. A parked owner whose slice ran out long ago is also exercised: a second request arrives late, and the grant must leave after exactly one cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned CFG_W    = 8;
  localparam int unsigned RES_BITS = 2;
  localparam logic [CFG_W-1:0] CFG_RST  = 8'h20;
  localparam logic [CFG_W-1:0] CFG_MASK = ~((CFG_W)'((1 << RES_BITS) - 1));
endpackage

// File: rtl/slice_cfg_reg.sv
module slice_cfg_reg
  import arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] q_o
);
  logic [CFG_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= CFG_RST;
    else if (we_i) q_q <= wdata_i & CFG_MASK;
  end

  assign q_o = q_q;
endmodule

// File: rtl/slice_timer.sv
module slice_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // last slice cycle is the one holding count 1 (or 0 when disabled)
  assign expired_o = (cnt_q <= W'(1));
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int unsigned N     = 4,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = last_i;
    for (int off = 1; off <= int'(N); off++) begin
      int cand;
      cand = (int'(last_i) + off) % int'(N);
      if (!vld_o && req_i[cand]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/bus_slice_arbiter.sv
module bus_slice_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_REQ = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o
);
  localparam int unsigned IDX_W = $clog2(N_REQ);
  localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(N_REQ - 1);

  logic [CFG_W-1:0] cfg_q;
  logic [N_REQ-1:0] gnt_q, gnt_d;
  logic [IDX_W-1:0] last_q, pick_idx;
  logic             pick_vld, load, expired, owner_req, others_req;

  slice_cfg_reg u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .q_o(cfg_q)
  );

  slice_timer #(.W(CFG_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(cfg_q),
    .run_i(|gnt_q), .expired_o(expired)
  );

  rr_picker #(.N(N_REQ)) u_pick (
    .req_i(req_i), .last_i(last_q), .vld_o(pick_vld), .idx_o(pick_idx)
  );

  assign owner_req  = |(req_i & gnt_q);
  assign others_req = |(req_i & ~gnt_q);

  always_comb begin
    gnt_d = gnt_q;
    load  = 1'b0;
    if (gnt_q == '0) begin
      if (pick_vld) begin
        gnt_d           = '0;
        gnt_d[pick_idx] = 1'b1;
        load            = 1'b1;
      end
    end else if (others_req && (expired || !owner_req)) begin
      gnt_d = '0; // idle cycle before hand-off
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= LAST_RST;
    end else begin
      gnt_q <= gnt_d;
      if (load) last_q <= pick_idx;
    end
  end

  assign gnt_o       = gnt_q;
  assign cfg_rdata_o = cfg_q;
endmodule

// File: rtl/slice_arb_checker.sv
module slice_arb_checker #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned CW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CW-1:0]    cfg_rdata_o,
  input logic [N_REQ-1:0] req_i,
  input logic [N_REQ-1:0] gnt_o
);
  logic [N_REQ-1:0] gnt_prev;
  logic [CW-1:0]    cfg_prev, cap_q, cap_c;
  logic [CW:0]      held_q, held_c;
  logic             new_g;

  assign new_g  = (gnt_o != '0) && (gnt_o != gnt_prev);
  assign cap_c  = new_g ? cfg_prev : cap_q;
  assign held_c = new_g ? '0 : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_prev <= '0;
      cfg_prev <= 8'h20;
      cap_q    <= '0;
      held_q   <= '0;
    end else begin
      gnt_prev <= gnt_o;
      cfg_prev <= cfg_rdata_o;
      cap_q    <= cap_c;
      if (gnt_o == '0)       held_q <= '0;
      else if (~&held_c)     held_q <= held_c + 1'b1;
      else                   held_q <= held_c;
    end
  end

  p_lowbits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[1:0] == 2'b00);

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_req_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |=> (gnt_o == '0 || (gnt_o & $past(req_i)) != '0));

  p_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |=> (gnt_o == '0 || gnt_o == $past(gnt_o)));

  p_slice_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (gnt_o & req_i) != '0 && ({1'b0, cap_c} > held_c + 1'b1))
    |=> gnt_o == $past(gnt_o));

  p_park_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (req_i & ~gnt_o) == '0) |=> gnt_o == $past(gnt_o));
endmodule

bind bus_slice_arbiter slice_arb_checker #(.N_REQ(N_REQ), .CW(8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_rdata_o(cfg_rdata_o),
  .req_i(req_i), .gnt_o(gnt_o)
);

// File: tb/tb_bus_slice_arbiter.sv
module tb_bus_slice_arbiter;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] req = '0;
  logic [3:0] gnt;
  int checks = 0;
  int errors = 0;
  int onehot_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_slice_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .req_i(req), .gnt_o(gnt)
  );

  always @(negedge clk) if (rst_n && !$onehot0(gnt)) onehot_bad++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic get_grant(output logic [3:0] g, output int len);
    int t = 0;
    while (gnt == '0 && t < 300) begin @(negedge clk); t++; end
    g = gnt; len = 0;
    while (gnt == g && len < 1000) begin len++; @(negedge clk); end
  endtask

  task automatic t_reset_cfg();
    do_reset();
    chk(gnt == 4'b0000, "R10 no grant after reset", gnt, 0);
    chk(cfg_rdata == 8'h20, "R1 reset value", cfg_rdata, 8'h20);
    cfg_write(8'hFF);
    chk(cfg_rdata == 8'hFC, "R1 low bits read zero", cfg_rdata, 8'hFC);
    cfg_write(8'h00);
    chk(cfg_rdata == 8'h00, "R1 write zero", cfg_rdata, 0);
  endtask

  task automatic t_slice_rr();
    logic [3:0] g; int len;
    do_reset();
    cfg_write(8'd8);
    req = 4'b0011;
    get_grant(g, len);
    chk(g == 4'b0001, "R10 agent0 first", g, 1);
    chk(len == 8, "R4 slice length 8", len, 8);
    chk(gnt == 4'b0000, "R3 idle gap", gnt, 0);
    get_grant(g, len);
    chk(g == 4'b0010, "R7 rotate to agent1", g, 2);
    chk(len == 8, "R4 second slice 8", len, 8);
    chk(gnt == 4'b0000, "R3 idle gap 2", gnt, 0);
    get_grant(g, len);
    chk(g == 4'b0001, "R7 wrap to agent0", g, 1);
    req = '0;
  endtask

  task automatic t_disabled();
    logic [3:0] g; int len;
    do_reset();
    cfg_write(8'h00);
    req = 4'b0111;
    for (int k = 0; k < 3; k++) begin
      get_grant(g, len);
      chk(g == (4'b0001 << k), "R7 order with slice off", g, 1 << k);
      chk(len == 1, "R5 zero slice one cycle", len, 1);
    end
    req = '0;
  endtask

  task automatic t_park();
    int bad = 0;
    do_reset();
    cfg_write(8'd4);
    req = 4'b0100;
    while (gnt == '0) @(negedge clk);
    chk(gnt == 4'b0100, "R2 grant to sole requester", gnt, 4);
    repeat (20) begin
      @(negedge clk);
      if (gnt != 4'b0100) bad++;
    end
    chk(bad == 0, "R6 parked owner keeps grant", bad, 0);
    req = 4'b1100;
    @(negedge clk);
    chk(gnt == 4'b0000, "R6 release after late request", gnt, 0);
    @(negedge clk);
    chk(gnt == 4'b1000, "R7 agent3 after agent2", gnt, 8);
    req = '0;
  endtask

  task automatic t_drop();
    do_reset();
    req = 4'b0101;
    while (gnt == '0) @(negedge clk);
    chk(gnt == 4'b0001, "R10 agent0 wins", gnt, 1);
    repeat (2) @(negedge clk);
    req = 4'b0100;
    @(negedge clk);
    chk(gnt == 4'b0000, "R8 early release", gnt, 0);
    @(negedge clk);
    chk(gnt == 4'b0100, "R8 waiting agent granted", gnt, 4);
    req = '0;
  endtask

  task automatic t_midwrite();
    logic [3:0] g; int len;
    do_reset();
    cfg_write(8'd12);
    req = 4'b0011;
    while (gnt == '0) @(negedge clk);
    g = gnt; len = 0;
    while (gnt == g && len < 1000) begin
      len++;
      if (len == 2) begin cfg_we = 1'b1; cfg_wdata = 8'd4; end
      else cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    chk(cfg_rdata == 8'd4, "R1 new value stored", cfg_rdata, 4);
    chk(len == 12, "R9 current slice unchanged", len, 12);
    get_grant(g, len);
    chk(g == 4'b0010, "R7 next agent", g, 2);
    chk(len == 4, "R9 new value at next grant", len, 4);
    req = '0;
  endtask

  initial begin
    t_reset_cfg();
    t_slice_rr();
    t_disabled();
    t_park();
    t_drop();
    t_midwrite();
    chk(onehot_bad == 0, "R2 one-hot monitor", onehot_bad, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule